// File: doc/BRIEF.md
# Character display instruction decoder

This block is the controller core that sits behind a character display's register port. A bus front end hands it single-cycle accesses, each made of a register-select bit, a read/write bit and a byte. The core then runs the display's instruction set against its own state. That state is a character store with one-line and two-line address maps, a small glyph-pattern store, a 7-bit address counter, entry-mode, display-control and function-set flags, a whole-display shift offset and a busy timer. Pixel generation, the character font, panel driving and bus timing sit outside it.

With register select low, a write is an instruction. The instruction is chosen by the highest set bit of the byte, and the bits below it are that instruction's fields. With register select high, an access moves data to or from whichever store the last address-set instruction selected. After such an access the address counter moves one place in the entry direction. Reads are answered from a prefetched output register, which is then refilled from the new address.

Each accepted access keeps the core busy for a parameter-set number of clock cycles. While it is busy, only the status read is served. Every other access is dropped and tallied in a saturating counter.

Top module: `chardisp_core`

## Requirements
- R1: After reset the address counter is 0, the character store is selected, the entry direction is upward, entire-display shift is off, display, cursor and blink are off, the wide bus is selected, one-line mode and short font are selected, the shift offset is 0, busy is low, the drop counter is 0 and every character cell holds 0x20.
- R2: With register select low and read low, the highest set bit of the byte picks the instruction: bit 7 sets the character-store address from bits 6..0, bit 6 sets the pattern-store address from bits 5..0, bit 5 is function set (bit 4 wide bus, bit 3 two lines, bit 2 tall font), bit 4 is cursor/display shift (bit 3 display-versus-cursor, bit 2 right), bit 3 is display control (bit 2 display, bit 1 cursor, bit 0 blink), bit 2 is entry mode (bit 1 upward, bit 0 shift on write), bit 1 is home and bit 0 is clear. A byte of 0x00 does nothing.
- R3: Clear fills every character cell with 0x20, sets the address counter to 0 in the character store, sets the entry direction to upward and returns the shift offset to 0.
- R4: Home sets the address counter to 0 in the character store and returns the shift offset to 0, and leaves the stored characters unchanged.
- R5: In two-line mode the character addresses are 0x00–0x27 and 0x40–0x67. Stepping up goes from 0x27 to 0x40 and from 0x67 to 0x00, and stepping down reverses these jumps. In one-line mode the addresses are 0x00–0x4F and wrap at both ends.
- R6: Every accepted data write or data read steps the address counter by one in the entry direction. In the pattern store the counter wraps within 6 bits.
- R7: A data write to the character store with shift-on-write set moves the shift offset by one: up when the entry direction is upward and down otherwise, modulo 40 in two-line mode and modulo 80 in one-line mode. Data reads and pattern-store accesses never move it.
- R8: A display shift (bit 3 set) moves the offset up for left and down for right, and leaves the address counter unchanged. A cursor shift steps the address counter right or left under the R5 map.
- R9: A data read returns the output register and then refills it from the new address. An address-set instruction refills it from the new address, and so does a cursor shift while the character store is selected.
- R10: Busy rises in the cycle after an accepted access and stays high for CLEAR_CYCLES cycles after clear or home, CMD_CYCLES after the other instructions and DATA_CYCLES after a data access.
- R11: Any access other than a status read that arrives while busy is high is ignored and increments the saturating drop counter.
- R12: A status read (register select low, read high) is served at any time without raising busy, and in the next cycle it returns busy in bit 7 and the address counter in bits 6..0 with the read-valid strobe.
- R13: Display control and function set drive the matching flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_rs | input | 1 | 0 selects instruction/status, 1 selects data |
| acc_rd | input | 1 | 1 for a read, 0 for a write |
| acc_data | input | 8 | Write byte |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | rd_data holds a new read result |
| busy | output | 1 | Instruction in progress |
| addr_ctr | output | 7 | Address counter |
| cg_mode | output | 1 | Pattern store selected |
| step_up | output | 1 | Entry direction upward |
| shift_on_write | output | 1 | Entire-display shift on writes |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_wide | output | 1 | Wide bus selected |
| two_line | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall font |
| disp_ofs | output | 7 | Whole-display shift offset |
| drop_cnt | output | 8 | Accesses dropped while busy |

## Verification
The assertions assume that the front end sets the character address only to values inside the current map. They also assume that the line mode is not switched from one to two lines while the address counter sits outside the two-line map. The stimulus therefore uses only in-map address-set values, and it switches to one-line mode only as its last mode change. Apart from the deliberate drop test, every access waits for busy to fall, so the busy-time and refill checks see accepted accesses.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

   typedef enum logic [3:0] {
      OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
      OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR
   } op_e;

   typedef enum logic [1:0] {BT_NONE, BT_CMD, BT_LONG, BT_DATA} btime_e;

   // highest set bit selects the instruction
   function automatic op_e decode_op(input logic [7:0] b);
      if (b[7])      return OP_DDADDR;
      else if (b[6]) return OP_CGADDR;
      else if (b[5]) return OP_FUNC;
      else if (b[4]) return OP_SHIFT;
      else if (b[3]) return OP_DISP;
      else if (b[2]) return OP_ENTRY;
      else if (b[1]) return OP_HOME;
      else if (b[0]) return OP_CLEAR;
      else           return OP_NONE;
   endfunction

endpackage

// File: rtl/chardisp_addr_step.sv
module chardisp_addr_step #(
   parameter int AW         = 7,
   parameter int CG_AW      = 6,
   parameter int LINE_LEN   = 40,
   parameter int LINE2_BASE = 64,
   parameter int ONE_LEN    = 80
) (
   input  logic [AW-1:0] cur,
   input  logic          up,
   input  logic          two_line,
   input  logic          cg_mode,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] L1_END = AW'(LINE_LEN - 1);
   localparam logic [AW-1:0] L2_BEG = AW'(LINE2_BASE);
   localparam logic [AW-1:0] L2_END = AW'(LINE2_BASE + LINE_LEN - 1);
   localparam logic [AW-1:0] O_END  = AW'(ONE_LEN - 1);

   if (LINE2_BASE < LINE_LEN || LINE2_BASE + LINE_LEN > 2**AW)
      $error("line 2 window does not fit the address space");
   if (CG_AW >= AW) $error("pattern address must be narrower than AW");

   logic [AW-1:0] inc_v, dec_v;
   assign inc_v = cur + 1'b1;
   assign dec_v = cur - 1'b1;

   always_comb begin
      if (cg_mode) begin
         nxt = up ? inc_v : dec_v;
         nxt[AW-1:CG_AW] = '0;
      end else if (two_line) begin
         if (up)                 nxt = (cur == L1_END) ? L2_BEG :
                                       (cur == L2_END) ? '0 : inc_v;
         else                    nxt = (cur == L2_BEG) ? L1_END :
                                       (cur == '0) ? L2_END : dec_v;
      end else begin
         if (up) nxt = (cur == O_END) ? '0 : inc_v;
         else    nxt = (cur == '0) ? O_END : dec_v;
      end
   end
endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer
   import chardisp_pkg::*;
#(
   parameter int CLEAR_CYCLES = 48,
   parameter int CMD_CYCLES   = 4,
   parameter int DATA_CYCLES  = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  btime_e kind,
   output logic   busy
);
   localparam int MAXC = (CLEAR_CYCLES > CMD_CYCLES) ?
                         ((CLEAR_CYCLES > DATA_CYCLES) ? CLEAR_CYCLES : DATA_CYCLES) :
                         ((CMD_CYCLES > DATA_CYCLES) ? CMD_CYCLES : DATA_CYCLES);
   localparam int CW = $clog2(MAXC + 1);

   if (CLEAR_CYCLES < 1 || CMD_CYCLES < 1 || DATA_CYCLES < 1)
      $error("busy durations must be at least one cycle");

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (start) begin
         unique case (kind)
            BT_LONG: cnt_q <= CW'(CLEAR_CYCLES);
            BT_CMD:  cnt_q <= CW'(CMD_CYCLES);
            BT_DATA: cnt_q <= CW'(DATA_CYCLES);
            default: cnt_q <= '0;
         endcase
      end else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/chardisp_store.sv
module chardisp_store #(
   parameter int          DD_DEPTH   = 80,
   parameter int          CG_DEPTH   = 64,
   parameter int          AW         = 7,
   parameter int          CG_AW      = 6,
   parameter int          DW         = 8,
   parameter int          LINE_LEN   = 40,
   parameter int          LINE2_BASE = 64,
   parameter logic [7:0]  FILL       = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic          w_cg,
   input  logic [AW-1:0] w_addr,
   input  logic [DW-1:0] w_data,
   input  logic          two_line,
   input  logic          r_cg,
   input  logic [AW-1:0] r_addr,
   output logic [DW-1:0] r_data
);
   localparam int DIW = $clog2(DD_DEPTH);

   if (CG_DEPTH != 2**CG_AW) $error("pattern depth must equal 2**CG_AW");
   if (DD_DEPTH != 2*LINE_LEN) $error("character depth must hold two lines");

   // character-store slot of an address, -1 outside the active map
   function automatic int slot_of(input logic [AW-1:0] a, input logic two);
      int v;
      v = int'(a);
      if (two) begin
         if (v < LINE_LEN) return v;
         if (v >= LINE2_BASE && v < LINE2_BASE + LINE_LEN) return v - LINE2_BASE + LINE_LEN;
         return -1;
      end
      return (v < DD_DEPTH) ? v : -1;
   endfunction

   logic [DW-1:0] dd_q [DD_DEPTH];
   logic [DW-1:0] cg_q [CG_DEPTH];
   int            w_slot, r_slot;
   logic          dd_we, cg_we;

   always_comb begin
      w_slot = slot_of(w_addr, two_line);
      r_slot = slot_of(r_addr, two_line);
   end
   assign dd_we = we && !w_cg && (w_slot >= 0);
   assign cg_we = we && w_cg;

   for (genvar i = 0; i < DD_DEPTH; i++) begin : g_dd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dd_q[i] <= DW'(FILL);
         else if (clr)                 dd_q[i] <= DW'(FILL);
         else if (dd_we && w_slot == i) dd_q[i] <= w_data;
      end
   end

   for (genvar j = 0; j < CG_DEPTH; j++) begin : g_cg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cg_q[j] <= '0;
         else if (cg_we && w_addr[CG_AW-1:0] == CG_AW'(j)) cg_q[j] <= w_data;
      end
   end

   always_comb begin
      if (r_cg)             r_data = cg_q[r_addr[CG_AW-1:0]];
      else if (r_slot >= 0) r_data = dd_q[r_slot[DIW-1:0]];
      else                  r_data = '0;
   end
endmodule

// File: rtl/chardisp_core.sv
module chardisp_core
   import chardisp_pkg::*;
#(
   parameter int DW           = 8,
   parameter int AW           = 7,
   parameter int CG_AW        = 6,
   parameter int DD_DEPTH     = 80,
   parameter int CG_DEPTH     = 64,
   parameter int LINE_LEN     = 40,
   parameter int LINE2_BASE   = 64,
   parameter int CLEAR_CYCLES = 48,
   parameter int CMD_CYCLES   = 4,
   parameter int DATA_CYCLES  = 5,
   parameter int DROP_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_rs,
   input  logic              acc_rd,
   input  logic [DW-1:0]     acc_data,
   output logic [DW-1:0]     rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic [AW-1:0]     addr_ctr,
   output logic              cg_mode,
   output logic              step_up,
   output logic              shift_on_write,
   output logic              disp_on,
   output logic              cursor_on,
   output logic              blink_on,
   output logic              bus_wide,
   output logic              two_line,
   output logic              tall_font,
   output logic [AW-1:0]     disp_ofs,
   output logic [DROP_W-1:0] drop_cnt
);
   if (DW != 8)      $error("instruction decode needs an 8-bit byte");
   if (AW + 1 != DW) $error("status word packs busy above the address counter");

   localparam logic [AW-1:0] LEN2 = AW'(LINE_LEN);
   localparam logic [AW-1:0] LEN1 = AW'(DD_DEPTH);

   // ---------------- access classification
   logic status_rd, take, drop;
   op_e  op;
   assign status_rd = acc_en && !acc_rs && acc_rd;
   assign take      = acc_en && !busy && !status_rd;
   assign drop      = acc_en &&  busy && !status_rd;
   assign op        = decode_op(acc_data);

   // ---------------- state
   logic [AW-1:0] ac_q, ac_n, ac_step, ofs_q, ofs_n, ofs_len, ofs_fwd, ofs_back;
   logic          cg_q, cg_n, inc_q, inc_n, sh_q, sh_n;
   logic          d_q, d_n, c_q, c_n, b_q, b_n, dl_q, dl_n, nl_q, nl_n, ft_q, ft_n;
   logic [DW-1:0] out_q, ram_rd;
   logic          pre, clr, wr_data, dir_up, bt_start;
   btime_e        bt_kind;

   assign dir_up = (!acc_rs && op == OP_SHIFT) ? acc_data[2] : inc_q;

   chardisp_addr_step #(
      .AW(AW), .CG_AW(CG_AW), .LINE_LEN(LINE_LEN),
      .LINE2_BASE(LINE2_BASE), .ONE_LEN(DD_DEPTH)
   ) u_step (
      .cur(ac_q), .up(dir_up), .two_line(nl_q), .cg_mode(cg_q), .nxt(ac_step)
   );

   assign ofs_len  = nl_q ? LEN2 : LEN1;
   assign ofs_fwd  = (ofs_q == ofs_len - 1'b1) ? '0 : ofs_q + 1'b1;
   assign ofs_back = (ofs_q == '0) ? ofs_len - 1'b1 : ofs_q - 1'b1;

   always_comb begin
      ac_n = ac_q;  cg_n = cg_q;  inc_n = inc_q; sh_n = sh_q;
      d_n  = d_q;   c_n  = c_q;   b_n   = b_q;
      dl_n = dl_q;  nl_n = nl_q;  ft_n  = ft_q;
      ofs_n = ofs_q; pre = 1'b0; clr = 1'b0; wr_data = 1'b0;
      bt_kind = BT_NONE;
      if (take) begin
         if (acc_rs) begin
            bt_kind = BT_DATA;
            ac_n    = ac_step;
            if (acc_rd) pre = 1'b1;
            else begin
               wr_data = 1'b1;
               if (!cg_q && sh_q) ofs_n = inc_q ? ofs_fwd : ofs_back;
            end
         end else begin
            bt_kind = BT_CMD;
            unique case (op)
               OP_CLEAR: begin
                  bt_kind = BT_LONG; clr = 1'b1;
                  ac_n = '0; cg_n = 1'b0; inc_n = 1'b1; ofs_n = '0;
               end
               OP_HOME: begin
                  bt_kind = BT_LONG; ac_n = '0; cg_n = 1'b0; ofs_n = '0;
               end
               OP_ENTRY: begin inc_n = acc_data[1]; sh_n = acc_data[0]; end
               OP_DISP: begin
                  d_n = acc_data[2]; c_n = acc_data[1]; b_n = acc_data[0];
               end
               OP_SHIFT: begin
                  if (acc_data[3]) ofs_n = acc_data[2] ? ofs_back : ofs_fwd;
                  else begin ac_n = ac_step; pre = !cg_q; end
               end
               OP_FUNC: begin
                  dl_n = acc_data[4]; nl_n = acc_data[3]; ft_n = acc_data[2];
               end
               OP_CGADDR: begin
                  cg_n = 1'b1; pre = 1'b1;
                  ac_n = {{(AW-CG_AW){1'b0}}, acc_data[CG_AW-1:0]};
               end
               OP_DDADDR: begin
                  cg_n = 1'b0; pre = 1'b1; ac_n = acc_data[AW-1:0];
               end
               default: bt_kind = BT_NONE;
            endcase
         end
      end
   end
   assign bt_start = (bt_kind != BT_NONE);

   chardisp_store #(
      .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .AW(AW), .CG_AW(CG_AW),
      .DW(DW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(wr_data), .w_cg(cg_q),
      .w_addr(ac_q), .w_data(acc_data), .two_line(nl_q),
      .r_cg(cg_n), .r_addr(ac_n), .r_data(ram_rd)
   );

   chardisp_busy_timer #(
      .CLEAR_CYCLES(CLEAR_CYCLES), .CMD_CYCLES(CMD_CYCLES), .DATA_CYCLES(DATA_CYCLES)
   ) u_busy (
      .clk(clk), .rst_n(rst_n), .start(bt_start), .kind(bt_kind), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q <= '0; cg_q <= 1'b0; inc_q <= 1'b1; sh_q <= 1'b0;
         d_q <= 1'b0; c_q <= 1'b0; b_q <= 1'b0;
         dl_q <= 1'b1; nl_q <= 1'b0; ft_q <= 1'b0;
         ofs_q <= '0; out_q <= '0; rd_data <= '0; rd_valid <= 1'b0;
         drop_cnt <= '0;
      end else begin
         ac_q <= ac_n; cg_q <= cg_n; inc_q <= inc_n; sh_q <= sh_n;
         d_q <= d_n; c_q <= c_n; b_q <= b_n;
         dl_q <= dl_n; nl_q <= nl_n; ft_q <= ft_n;
         ofs_q <= ofs_n;
         if (pre) out_q <= ram_rd;
         rd_valid <= status_rd || (take && acc_rs && acc_rd);
         if (status_rd)                    rd_data <= {busy, ac_q};
         else if (take && acc_rs && acc_rd) rd_data <= out_q;
         if (drop && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
      end
   end

   assign addr_ctr = ac_q;   assign cg_mode   = cg_q;
   assign step_up  = inc_q;  assign shift_on_write = sh_q;
   assign disp_on  = d_q;    assign cursor_on = c_q;  assign blink_on = b_q;
   assign bus_wide = dl_q;   assign two_line  = nl_q; assign tall_font = ft_q;
   assign disp_ofs = ofs_q;
endmodule

// File: rtl/chardisp_chk.sv
module chardisp_chk #(
   parameter int DW         = 8,
   parameter int AW         = 7,
   parameter int LINE_LEN   = 40,
   parameter int LINE2_BASE = 64,
   parameter int DROP_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_rs,
   input logic              acc_rd,
   input logic [DW-1:0]     acc_data,
   input logic              rd_valid,
   input logic              busy,
   input logic [AW-1:0]     addr_ctr,
   input logic              cg_mode,
   input logic              step_up,
   input logic              two_line,
   input logic [AW-1:0]     disp_ofs,
   input logic [DROP_W-1:0] drop_cnt
);
   logic is_status, accepted;
   assign is_status = acc_en && !acc_rs && acc_rd;
   assign accepted  = acc_en && !busy && !is_status;

   a_r11_drop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && busy && !is_status) |=>
         ($stable(addr_ctr) && $stable(disp_ofs) && $stable(cg_mode)));

   a_r11_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && busy && !is_status) |=>
         (drop_cnt == $past(drop_cnt) + 1'b1 || $past(drop_cnt) == '1));

   a_r12_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (is_status && !busy) |=> (!busy && rd_valid));

   a_r10_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && (acc_rs || acc_data != '0)) |=> busy);

   a_r3_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && !acc_rs && acc_data == 8'h01) |=>
         (addr_ctr == '0 && step_up && disp_ofs == '0 && !cg_mode));

   a_r8_disp_shift_keeps_ac: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && !acc_rs && acc_data[7:4] == 4'b0001 && acc_data[3]) |=>
         $stable(addr_ctr));

   a_r5_two_line_map: assert property (@(posedge clk) disable iff (!rst_n)
      (!cg_mode && two_line) |->
         (int'(addr_ctr) < LINE_LEN ||
          (int'(addr_ctr) >= LINE2_BASE && int'(addr_ctr) < LINE2_BASE + LINE_LEN)));
endmodule

bind chardisp_core chardisp_chk #(
   .DW(DW), .AW(AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE), .DROP_W(DROP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_rs(acc_rs), .acc_rd(acc_rd),
   .acc_data(acc_data), .rd_valid(rd_valid), .busy(busy), .addr_ctr(addr_ctr),
   .cg_mode(cg_mode), .step_up(step_up), .two_line(two_line),
   .disp_ofs(disp_ofs), .drop_cnt(drop_cnt)
);

// File: tb/chardisp_core_tb.sv
module chardisp_core_tb;
   localparam int CLR_C = 48, CMD_C = 4, DAT_C = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic acc_en = 1'b0, acc_rs = 1'b0, acc_rd = 1'b0;
   logic [7:0] acc_data = '0, rd_data, drop_cnt;
   logic rd_valid, busy, cg_mode, step_up, shift_on_write, disp_on, cursor_on;
   logic blink_on, bus_wide, two_line, tall_font;
   logic [6:0] addr_ctr, disp_ofs;

   always #2 clk = ~clk;

   chardisp_core #(.CLEAR_CYCLES(CLR_C), .CMD_CYCLES(CMD_C), .DATA_CYCLES(DAT_C)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_rs(acc_rs), .acc_rd(acc_rd),
      .acc_data(acc_data), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
      .addr_ctr(addr_ctr), .cg_mode(cg_mode), .step_up(step_up),
      .shift_on_write(shift_on_write), .disp_on(disp_on), .cursor_on(cursor_on),
      .blink_on(blink_on), .bus_wide(bus_wide), .two_line(two_line),
      .tall_font(tall_font), .disp_ofs(disp_ofs), .drop_cnt(drop_cnt)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int m_dd[80];
   int m_cg[64];
   int m_ac = 0, m_out = 0, m_ofs = 0;
   bit m_cgm = 0, m_inc = 1, m_sh = 0, m_two = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int mstep(int a, bit up, bit two, bit cg);
      if (cg) return up ? (a + 1) % 64 : (a + 63) % 64;
      if (two) begin
         if (up) return (a == 'h27) ? 'h40 : (a == 'h67) ? 0 : a + 1;
         return (a == 'h40) ? 'h27 : (a == 0) ? 'h67 : a - 1;
      end
      if (up) return (a == 'h4F) ? 0 : a + 1;
      return (a == 0) ? 'h4F : a - 1;
   endfunction

   function automatic int mslot(int a, bit two);
      if (two) return (a < 40) ? a : (a >= 'h40 && a < 'h68) ? a - 'h40 + 40 : -1;
      return (a < 80) ? a : -1;
   endfunction

   function automatic int mofs(int o, bit fwd, bit two);
      int len = two ? 40 : 80;
      return fwd ? (o + 1) % len : (o + len - 1) % len;
   endfunction

   function automatic int mread(int a, bit cg);
      int s;
      if (cg) return m_cg[a % 64];
      s = mslot(a, m_two);
      return (s >= 0) ? m_dd[s] : 0;
   endfunction

   task automatic acc(input logic rs, input logic rd, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_rs = rs; acc_rd = rd; acc_data = d;
      @(negedge clk);
      acc_en = 1'b0; acc_rs = 1'b0; acc_rd = 1'b0; acc_data = '0;
   endtask

   task automatic busy_len(input string tag, input int exp);
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      check(tag, n, exp);
   endtask

   task automatic state(input string tag);
      check({tag, " ac"}, addr_ctr, m_ac);
      check({tag, " ofs"}, disp_ofs, m_ofs);
      check({tag, " cgsel"}, cg_mode, m_cgm);
   endtask

   task automatic cmd(input logic [7:0] d);
      int s;
      acc(1'b0, 1'b0, d);
      busy_len("R10 cmd busy", (d == 0) ? 0 : (d < 4) ? CLR_C : CMD_C);
      if (d[7]) begin m_cgm = 0; m_ac = d & 'h7F; m_out = mread(m_ac, 0); end
      else if (d[6]) begin m_cgm = 1; m_ac = d & 'h3F; m_out = mread(m_ac, 1); end
      else if (d[5]) m_two = d[3];
      else if (d[4]) begin
         if (d[3]) m_ofs = mofs(m_ofs, !d[2], m_two);
         else begin
            m_ac = mstep(m_ac, d[2], m_two, m_cgm);
            if (!m_cgm) m_out = mread(m_ac, 0);
         end
      end
      else if (d[3]) s = 0;
      else if (d[2]) begin m_inc = d[1]; m_sh = d[0]; end
      else if (d[1]) begin m_ac = 0; m_cgm = 0; m_ofs = 0; end
      else if (d[0]) begin
         for (int i = 0; i < 80; i++) m_dd[i] = 'h20;
         m_ac = 0; m_cgm = 0; m_inc = 1; m_ofs = 0;
      end
   endtask

   task automatic wr(input logic [7:0] d);
      int s;
      acc(1'b1, 1'b0, d);
      busy_len("R10 data busy", DAT_C);
      if (m_cgm) m_cg[m_ac % 64] = d;
      else begin
         s = mslot(m_ac, m_two);
         if (s >= 0) m_dd[s] = d;
         if (m_sh) m_ofs = mofs(m_ofs, m_inc, m_two);
      end
      m_ac = mstep(m_ac, m_inc, m_two, m_cgm);
   endtask

   task automatic rd(input string tag);
      acc(1'b1, 1'b1, 8'h00);
      check({tag, " rdata"}, rd_data, m_out);
      check({tag, " rvalid"}, rd_valid, 1);
      busy_len("R10 read busy", DAT_C);
      m_ac = mstep(m_ac, m_inc, m_two, m_cgm);
      m_out = mread(m_ac, m_cgm);
   endtask

   initial begin
      for (int i = 0; i < 80; i++) m_dd[i] = 'h20;
      for (int i = 0; i < 64; i++) m_cg[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ac", addr_ctr, 0);          check("R1 busy", busy, 0);
      check("R1 inc", step_up, 1);          check("R1 sh", shift_on_write, 0);
      check("R1 disp", {disp_on, cursor_on, blink_on}, 0);
      check("R1 modes", {bus_wide, two_line, tall_font}, 3'b100);
      check("R1 ofs", disp_ofs, 0);         check("R1 drop", drop_cnt, 0);
      check("R1 cgsel", cg_mode, 0);
      rd("R1 initial cell");

      // R13 function set and display control; R2 field positions
      cmd(8'h38);
      check("R13 func", {bus_wide, two_line, tall_font}, 3'b110);
      cmd(8'h0D);
      check("R13 dispctl", {disp_on, cursor_on, blink_on}, 3'b101);
      cmd(8'h06);
      check("R2 entry", {step_up, shift_on_write}, 2'b10);

      // R5 R6 sweep of the two-line map going up
      cmd(8'h80);
      for (int i = 0; i < 80; i++) begin
         wr(8'((i * 7 + 3) & 'hFF));
         check("R5 up step", addr_ctr, m_ac);
      end
      check("R5 wrap to 0", addr_ctr, 0);
      // R9 read back through the prefetch register
      cmd(8'h80);
      for (int i = 0; i < 80; i++) begin
         rd("R9 sweep");
         check("R6 read step", addr_ctr, m_ac);
      end

      // R5 stepping down across the gap
      cmd(8'h04); cmd(8'hC0); wr(8'h11);
      check("R5 down gap", addr_ctr, 'h27);
      cmd(8'h80); wr(8'h12);
      check("R5 down wrap", addr_ctr, 'h67);
      cmd(8'h06);

      // R7 shift on write
      cmd(8'h07); cmd(8'h80); wr(8'h21); state("R7 left");
      cmd(8'h05); wr(8'h22); state("R7 right");
      wr(8'h23); state("R7 right wrap");
      check("R7 ofs 39", disp_ofs, 39);
      cmd(8'h82); rd("R7 read"); state("R7 read no shift");
      cmd(8'h41); wr(8'h5C); state("R7 cg no shift");
      cmd(8'h06);

      // R8 cursor/display shift
      cmd(8'h80); cmd(8'h18); state("R8 disp left");
      cmd(8'h1C); state("R8 disp right");
      cmd(8'h85); cmd(8'h14); state("R8 cursor right");
      rd("R9 after cursor shift");
      cmd(8'h10); state("R8 cursor left");
      cmd(8'hA7); cmd(8'h14); state("R8 cursor gap");

      // R6 pattern store sweep
      cmd(8'h40);
      for (int i = 0; i < 64; i++) begin
         wr(8'(i ^ 'hA5));
         check("R6 cg step", addr_ctr, m_ac);
      end
      check("R6 cg wrap", addr_ctr, 0);
      cmd(8'h40);
      for (int i = 0; i < 64; i++) rd("R9 cg sweep");

      // R2 highest-bit decode with set lower bits
      cmd(8'h7F); state("R2 cgaddr 7F");
      check("R2 ac 3F", addr_ctr, 'h3F);
      cmd(8'h3F);
      check("R2 func 3F", {bus_wide, two_line, tall_font}, 3'b111);
      cmd(8'h0F);
      check("R2 disp 0F", {disp_on, cursor_on, blink_on}, 3'b111);
      cmd(8'h1F); state("R2 shift 1F");
      cmd(8'h00); state("R2 nop");
      cmd(8'h03); state("R4 home");
      check("R4 ofs", disp_ofs, 0);
      cmd(8'h80); for (int i = 0; i < 6; i++) rd("R4 kept");

      // R3 clear
      cmd(8'h04); cmd(8'h01); state("R3 clear");
      check("R3 inc", step_up, 1);
      cmd(8'h80);
      for (int i = 0; i < 80; i++) rd("R3 filled");

      // R12 R11 status and drops while busy
      acc(1'b0, 1'b1, 8'h00);
      check("R12 status idle", rd_data, {1'b0, addr_ctr});
      check("R12 no busy", busy, 0);
      acc(1'b0, 1'b0, 8'h01);
      acc(1'b1, 1'b0, 8'h55);
      check("R11 drop count", drop_cnt, 1);
      acc(1'b0, 1'b0, 8'h80);
      check("R11 drop count 2", drop_cnt, 2);
      acc(1'b0, 1'b1, 8'h00);
      check("R12 status busy", rd_data, 8'h80);
      while (busy) @(negedge clk);
      for (int i = 0; i < 80; i++) m_dd[i] = 'h20;
      m_ac = 0; m_cgm = 0; m_inc = 1; m_ofs = 0;
      state("R11 ignored");
      rd("R11 no write");

      // R5 R7 one-line mode
      cmd(8'h30);
      check("R13 one line", two_line, 0);
      cmd(8'hCF); wr(8'h31); state("R5 one-line wrap");
      cmd(8'hA7); wr(8'h32); state("R5 one-line no gap");
      cmd(8'h1C); state("R8 one-line ofs");
      check("R8 ofs 79", disp_ofs, 79);
      cmd(8'h18); state("R8 one-line back");

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule